// File: doc/BRIEF.md
# Lowest-Cycle-Count Shared Bus Arbiter

This block decides which of several bus masters may use a shared-memory bus next. Each master that wants the bus raises its request line and, on the same cycle, presents its own local cycle count as a 32-bit unsigned number. When the bus is free, the arbiter compares every pending count in one clock cycle and grants the master with the smallest count. This lets the cores that have fallen furthest behind in local time reach shared memory first, which keeps them in step with each other. If two or more masters report the same lowest count, the master with the lower index wins.

A grant is a one-hot vector. It stays on the same master until that master pulses its done line. The bus then stays free for one full cycle before any new grant. Slaves have no request line. A done pulse from a master that does not hold the grant changes nothing, and the arbiter reports it on the error output.

The controller has two named states. `ARB_IDLE` means no owner. Its transition *claim* goes to `ARB_OWNED` on the clock edge where any request is present, and it loads the winner's grant. `ARB_OWNED` holds the grant. Its transition *release* returns to `ARB_IDLE` on the edge where the owner's done is seen, and it clears the grant. Every other input leaves the state as it is.

Top module: `cyc_arbiter`

## Requirements
- R1: After reset, gnt_o is all zero and err_o is 0.
- R2: A master that is not requesting is never newly granted, and with no request pending gnt_o stays all zero.
- R3: gnt_o has at most one bit set in every cycle.
- R4: From the idle state, the grant goes to the requesting master whose cyc_i field (bits i*32 to i*32+31 for master i) holds the smallest value.
- R5: If several requesters share the smallest count, the one with the lowest index is granted.
- R6: While a master holds the grant, gnt_o stays unchanged whatever req_i, cyc_i or other masters' done lines do.
- R7: On the edge where the owner's done_i bit is 1, gnt_o clears. The next grant can appear no earlier than the following edge, so at least one cycle of all-zero gnt_o separates two owners.
- R8: A done_i bit set for a master that does not hold the grant, including while idle, sets err_o for exactly the next cycle and changes nothing in gnt_o.
- R9: From the idle state, the grant appears on the first clock edge at which a request is sampled.
- R10: Counts are compared as unsigned numbers. For example, 32'h7FFF_FFFF is smaller than 32'h8000_0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | NUM_M | Request line per master |
| cyc_i | input | NUM_M*CNT_W | Local cycle count per master, master i in bits i*CNT_W upward |
| done_i | input | NUM_M | End-of-transfer pulse per master |
| gnt_o | output | NUM_M | One-hot grant |
| err_o | output | 1 | One-cycle flag for a done pulse from a non-owner |

## Verification
The bench drives count patterns in which the lowest value is on a high index while a low index also requests. A design that picks by fixed priority would therefore grant the wrong master. It also drives equal counts, where a design with a non-strict compare would hand ties to the highest index. A count pair that straddles bit 31 catches a signed compare. Other cases check that the grant is held while requests change and while stray done pulses arrive, that exactly one empty cycle follows each release, and that a stray done, including one that arrives together with the owner's done, raises err_o. A design that wrongly accepted the stray done would show a dropped or changed grant.

// File: rtl/arb_pkg.sv
package arb_pkg;
    typedef enum logic [0:0] {
        ARB_IDLE  = 1'b0,
        ARB_OWNED = 1'b1
    } arb_state_t;
endpackage

// File: rtl/arb_pick.sv
// Parallel minimum search over all requesting masters.
module arb_pick #(
    parameter int NUM_M = 4,
    parameter int CNT_W = 32
) (
    input  logic [NUM_M-1:0]       req,
    input  logic [NUM_M*CNT_W-1:0] cyc,
    output logic [NUM_M-1:0]       win_oh,
    output logic                   any_req
);
    logic [CNT_W-1:0] cnt [NUM_M];

    for (genvar g = 0; g < NUM_M; g++) begin : g_unpack
        assign cnt[g] = cyc[g*CNT_W +: CNT_W];
    end

    logic [CNT_W-1:0] best;
    logic             found;

    always_comb begin
        best   = '0;
        found  = 1'b0;
        win_oh = '0;
        for (int i = 0; i < NUM_M; i++) begin
            // strict compare: an equal count never displaces a lower index
            if (req[i] && (!found || cnt[i] < best)) begin
                best   = cnt[i];
                found  = 1'b1;
                win_oh = '0;
                win_oh[i] = 1'b1;
            end
        end
    end

    assign any_req = |req;
endmodule

// File: rtl/arb_fsm.sv
module arb_fsm
    import arb_pkg::*;
#(
    parameter int NUM_M = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             any_req,
    input  logic [NUM_M-1:0] win_oh,
    input  logic [NUM_M-1:0] req,
    input  logic [NUM_M-1:0] done,
    output logic [NUM_M-1:0] gnt,
    output logic             err
);
    arb_state_t       state_q, state_d;
    logic [NUM_M-1:0] gnt_d;
    logic             err_d;
    logic             owner_done;

    assign owner_done = |(done & gnt);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ARB_IDLE;
            gnt     <= '0;
            err     <= 1'b0;
        end else begin
            state_q <= state_d;
            gnt     <= gnt_d;
            err     <= err_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        gnt_d   = gnt;
        err_d   = |(done & ~gnt);
        unique case (state_q)
            ARB_IDLE: begin
                if (any_req) begin
                    state_d = ARB_OWNED;
                    gnt_d   = win_oh;
                end
            end
            ARB_OWNED: begin
                if (owner_done) begin
                    state_d = ARB_IDLE;
                    gnt_d   = '0;
                end
            end
            default: begin
                state_d = ARB_IDLE;
                gnt_d   = '0;
            end
        endcase
    end

    a_r3_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    a_r2_only_requester: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt == '0) |=> ((gnt & ~$past(req)) == '0));

    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt != '0) && !owner_done) |=> (gnt == $past(gnt)));

    a_r7_gap: assert property (@(posedge clk) disable iff (!rst_n)
        owner_done |=> (gnt == '0));

    a_r8_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ((done & ~gnt) != '0) |=> err);

    a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((done & ~gnt) == '0) |=> !err);
endmodule

// File: rtl/cyc_arbiter.sv
module cyc_arbiter #(
    parameter int NUM_M = 4,
    parameter int CNT_W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_M-1:0]       req_i,
    input  logic [NUM_M*CNT_W-1:0] cyc_i,
    input  logic [NUM_M-1:0]       done_i,
    output logic [NUM_M-1:0]       gnt_o,
    output logic                   err_o
);
    logic [NUM_M-1:0] win_oh;
    logic             any_req;

    arb_pick #(.NUM_M(NUM_M), .CNT_W(CNT_W)) u_pick (
        .req     (req_i),
        .cyc     (cyc_i),
        .win_oh  (win_oh),
        .any_req (any_req)
    );

    arb_fsm #(.NUM_M(NUM_M)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .any_req (any_req),
        .win_oh  (win_oh),
        .req     (req_i),
        .done    (done_i),
        .gnt     (gnt_o),
        .err     (err_o)
    );
endmodule

// File: tb/sim_cyc_arbiter.sv
`timescale 1ns/1ps
module sim_cyc_arbiter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  req = '0;
    logic [127:0] cyc = '0;
    logic [3:0]  done = '0;
    logic [3:0]  gnt;
    logic        err;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [3:0] q_gnt [$];
    logic       q_err [$];
    string      q_tag [$];

    always #4 clk = ~clk;

    cyc_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req), .cyc_i(cyc),
        .done_i(done), .gnt_o(gnt), .err_o(err)
    );

    // driver: applies one cycle of stimulus and queues the expected result
    task automatic drive(input logic [3:0] r,
                         input logic [31:0] c0, input logic [31:0] c1,
                         input logic [31:0] c2, input logic [31:0] c3,
                         input logic [3:0] d,
                         input logic [3:0] eg, input logic ee,
                         input string tag);
        @(negedge clk);
        req  = r;
        cyc  = {c3, c2, c1, c0};
        done = d;
        q_gnt.push_back(eg);
        q_err.push_back(ee);
        q_tag.push_back(tag);
    endtask

    // monitor: compares after each edge, away from the edge itself
    always @(posedge clk) begin
        #2;
        if (q_gnt.size() > 0) begin
            logic [3:0] eg;
            logic       ee;
            string      t;
            eg = q_gnt.pop_front();
            ee = q_err.pop_front();
            t  = q_tag.pop_front();
            checks++;
            if (gnt !== eg) begin
                errors++;
                $display("FAIL %s gnt actual=%b expected=%b", t, gnt, eg);
            end
            checks++;
            if (err !== ee) begin
                errors++;
                $display("FAIL %s err actual=%b expected=%b", t, err, ee);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state with nothing pending
        drive(4'b0000, 0, 0, 0, 0, 4'b0000, 4'b0000, 1'b0, "R1 reset");
        // R4 R9: m3 has smallest count though m1,m2 also request
        drive(4'b1110, 100, 50, 70, 20, 4'b0000, 4'b1000, 1'b0, "R4 lowest");
        // R6: a smaller newcomer does not steal the grant
        drive(4'b1111, 1, 50, 70, 20, 4'b0000, 4'b1000, 1'b0, "R6 hold");
        // R8: stray done from m1 flags and is ignored
        drive(4'b1111, 1, 50, 70, 20, 4'b0010, 4'b1000, 1'b1, "R8 stray");
        // R7: owner releases, one empty cycle
        drive(4'b0111, 1, 5, 5, 0, 4'b1000, 4'b0000, 1'b0, "R7 release");
        // R5: m1 and m2 tie at 5, m1 wins
        drive(4'b0111, 9, 5, 5, 0, 4'b0000, 4'b0010, 1'b0, "R5 tie");
        // R7 R8: owner done with stray m0 done together
        drive(4'b0000, 0, 0, 0, 0, 4'b0011, 4'b0000, 1'b1, "R7 R8 both");
        // R10: unsigned compare across bit 31
        drive(4'b1001, 32'h8000_0000, 0, 0, 32'h7FFF_FFFF, 4'b0000, 4'b1000, 1'b0, "R10 unsigned");
        drive(4'b0000, 0, 0, 0, 0, 4'b1000, 4'b0000, 1'b0, "R7 release2");
        // R2: no request, no grant
        drive(4'b0000, 0, 0, 0, 0, 4'b0000, 4'b0000, 1'b0, "R2 none");
        // R8: done while idle
        drive(4'b0000, 0, 0, 0, 0, 4'b0100, 4'b0000, 1'b1, "R8 idle done");
        // R5: all equal, m0 wins
        drive(4'b1111, 7, 7, 7, 7, 4'b0000, 4'b0001, 1'b0, "R5 all equal");
        // R6: requests drop, grant stays
        drive(4'b0000, 7, 7, 7, 7, 4'b0000, 4'b0001, 1'b0, "R6 req drop");
        drive(4'b0000, 0, 0, 0, 0, 4'b0001, 4'b0000, 1'b0, "R7 release3");
        // R2 R3: idle again
        drive(4'b0000, 0, 0, 0, 0, 4'b0000, 4'b0000, 1'b0, "R2 R3 idle");
        @(negedge clk);
        done = '0;
        req  = '0;
        while (q_gnt.size() > 0) @(negedge clk);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 5000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule